// File: doc/BRIEF.md
# Standby Mode Sequencer

This block decides which clock domains of a small microcontroller may run. It drives separate enables for the CPU clock, the internal system clock, the oscillator and the PLL, and an enable for the clock-output pin. The CPU enters the lightest standby depth, HALT, with a one-cycle strobe. The two deeper depths, IDLE and STOP, are requested through a register write that must be unlocked first. An unmasked interrupt or an NMI ends any standby depth. A synchronous reset also ends it.

STOP is the deepest depth and turns every clock source off. Leaving STOP takes time. The block first counts a programmable number of oscillator cycles. It then waits for the PLL lock input if software has asked it to. The CPU and system clocks return only after that wait. A STOP request is refused while the clock generator bypasses the PLL. HALT and IDLE keep the oscillator and the PLL alive, so both return to normal operation on the cycle after the wake event.

Top module: `pwr_mode_ctl`

## Requirements
- R1: In HALT only `cpu_clk_en` is low. HALT is entered from normal mode on the cycle after `halt_req`. A standby-control write accepted in the same cycle as `halt_req` takes precedence over it.
- R2: An accepted write to address 1 with data bits [1:0] = 01 enters IDLE. IDLE lowers `cpu_clk_en` and `sys_clk_en` and keeps `osc_en` and `pll_en` high. A wake event returns all clock enables to high on the next cycle.
- R3: An accepted write to address 1 with data bits [1:0] = 10 enters STOP, in which all four clock enables are low. STOP persists until a wake event.
- R4: A wake event in STOP starts a stabilization phase of N+1 cycles, where N is the programmed count. During this phase `osc_en` and `pll_en` are high and `cpu_clk_en` and `sys_clk_en` are low.
- R5: If the PLL-wait bit (bit 8 of the address 2 write) is set, the stabilization phase is followed by a wait. The wait holds the CPU and system clocks off until `pll_lock` is high, and normal mode starts on the cycle after that.
- R6: A STOP request accepted while `pll_bypass` is high leaves the block in normal mode.
- R7: `clkout_en` is high only when the system clock runs and `clkout_inhibit` is low.
- R8: Writes to addresses 1 and 2 are accepted only when the write just before them went to address 0 with bits [7:0] = 8'hA5. A rejected write changes nothing and sets `prot_err`. An accepted write clears `prot_err`.
- R9: `irq_wake` or `nmi` releases HALT, IDLE or STOP. Both are ignored in normal mode.
- R10: After reset the block is in normal mode with all enables high and `prot_err` low. The stabilization count is 16 and the PLL-wait bit is clear.
- R11: `mode_status` encodes the state as follows: 0 normal, 1 HALT, 2 IDLE, 3 STOP, 4 stabilizing (this includes the PLL wait).
- R12: An address 2 write accepted under R8 loads bits [7:0] as the count N and bit 8 as the PLL-wait bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | One-cycle strobe from the halt instruction |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 unlock, 1 standby control, 2 timing, 3 reserved |
| reg_wdata | input | 9 | Register write data |
| irq_wake | input | 1 | Unmasked maskable interrupt pending |
| nmi | input | 1 | Non-maskable interrupt |
| pll_bypass | input | 1 | Clock generator runs in direct (PLL-bypass) mode |
| pll_lock | input | 1 | PLL lock indication |
| clkout_inhibit | input | 1 | Forces the clock-output pin enable low |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| sys_clk_en | output | 1 | Internal system clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| clkout_en | output | 1 | Clock-output pin enable |
| mode_status | output | 3 | Current standby depth, encoded as in R11 |
| prot_err | output | 1 | Protection error flag |

## Verification
The state register drives every enable through decode only, so a wrong state shows at the ports within one cycle. It appears as an enable pattern that no legal depth produces, or as a disagreement between `mode_status` and the enables. A stabilization counter that is off by one shows as a stabilization phase that is one cycle too long or too short, measured from the wake event. A protection flaw shows as a depth change after a write that should have been rejected, or as `prot_err` staying low on the cycle after that write.

// File: rtl/pwr_mode_pkg.sv
// Shared definitions for the standby mode sequencer.
// Assumes a 3-bit state code whose first five values are also the status code.
package pwr_mode_pkg;
    typedef enum logic [2:0] {
        PM_NORMAL = 3'd0,
        PM_HALT   = 3'd1,
        PM_IDLE   = 3'd2,
        PM_STOP   = 3'd3,
        PM_STAB   = 3'd4,
        PM_LOCKW  = 3'd5
    } pm_state_t;

    localparam logic [1:0] ADDR_UNLOCK = 2'd0;
    localparam logic [1:0] ADDR_MODE   = 2'd1;
    localparam logic [1:0] ADDR_TIMING = 2'd2;

    localparam logic [1:0] REQ_IDLE = 2'b01;
    localparam logic [1:0] REQ_STOP = 2'b10;
endpackage

// File: rtl/pwr_reg_guard.sv
// Protected register access for the standby sequencer.
// Passes a standby request through, and holds the timing settings, only when the
// write right before it was the unlock key. Any other protected write sets an error flag.
// Assumes the register bus issues at most one write per cycle.
module pwr_reg_guard
    import pwr_mode_pkg::*;
#(
    parameter int          CNT_W        = 8,
    parameter int          DW           = 9,
    parameter logic [7:0]  KEY          = 8'hA5,
    parameter int unsigned STAB_DEFAULT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic             req_valid,
    output logic [1:0]       req_mode,
    output logic [CNT_W-1:0] stab_cnt,
    output logic             pll_wait,
    output logic             prot_err
);
    logic armed;
    logic prot_wr;
    logic accept;

    assign prot_wr   = reg_wr && (reg_addr == ADDR_MODE || reg_addr == ADDR_TIMING);
    assign accept    = prot_wr && armed;
    assign req_valid = accept && (reg_addr == ADDR_MODE);
    assign req_mode  = reg_wdata[1:0];

    // Arm on a key write; any other write disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (reg_wr)
            armed <= (reg_addr == ADDR_UNLOCK) && (reg_wdata[7:0] == KEY);
    end

    // Hold the stabilization count and the PLL-wait choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stab_cnt <= CNT_W'(STAB_DEFAULT);
            pll_wait <= 1'b0;
        end else if (accept && reg_addr == ADDR_TIMING) begin
            stab_cnt <= reg_wdata[CNT_W-1:0];
            pll_wait <= reg_wdata[CNT_W];
        end
    end

    // Flag a rejected protected write; clear on an accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_err <= 1'b0;
        else if (prot_wr && !armed)
            prot_err <= 1'b1;
        else if (accept)
            prot_err <= 1'b0;
    end

    AST_UNPROT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && !armed) |=> (prot_err && $stable(stab_cnt) && $stable(pll_wait))); // R8
endmodule

// File: rtl/pwr_stab_timer.sv
// Down-counter for the oscillator stabilization interval.
// Assumes load and run never both assert; done reads true when the count is zero.
module pwr_stab_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Load the interval, then count down to zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !done) |=> (cnt == $past(cnt) - 1'b1)); // R4
endmodule

// File: rtl/pwr_mode_ctl.sv
// Standby mode sequencer: moves between normal, HALT, IDLE and STOP and decodes the
// clock enables. Exit from STOP passes through a counted stabilization phase and an
// optional PLL lock wait.
// Assumes irq_wake already has masking applied, and halt_req lasts one cycle.
module pwr_mode_ctl
    import pwr_mode_pkg::*;
#(
    parameter int          CNT_W        = 8,
    parameter logic [7:0]  UNLOCK_KEY   = 8'hA5,
    parameter int unsigned STAB_DEFAULT = 16,
    localparam int         DW           = (CNT_W + 1 > 8) ? CNT_W + 1 : 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_req,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          irq_wake,
    input  logic          nmi,
    input  logic          pll_bypass,
    input  logic          pll_lock,
    input  logic          clkout_inhibit,
    output logic          cpu_clk_en,
    output logic          sys_clk_en,
    output logic          osc_en,
    output logic          pll_en,
    output logic          clkout_en,
    output logic [2:0]    mode_status,
    output logic          prot_err
);
    pm_state_t        state;
    pm_state_t        state_nx;
    logic             wake;
    logic             req_valid;
    logic [1:0]       req_mode;
    logic [CNT_W-1:0] stab_cnt;
    logic             pll_wait;
    logic             tmr_load;
    logic             tmr_done;

    assign wake = irq_wake || nmi;

    pwr_reg_guard #(
        .CNT_W       (CNT_W),
        .DW          (DW),
        .KEY         (UNLOCK_KEY),
        .STAB_DEFAULT(STAB_DEFAULT)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .req_valid(req_valid),
        .req_mode (req_mode),
        .stab_cnt (stab_cnt),
        .pll_wait (pll_wait),
        .prot_err (prot_err)
    );

    pwr_stab_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(stab_cnt),
        .run     (state == PM_STAB),
        .done    (tmr_done)
    );

    // Choose the next standby depth from requests, wake events and the timer.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        case (state)
            PM_NORMAL: begin
                if (req_valid && req_mode == REQ_IDLE)
                    state_nx = PM_IDLE;
                else if (req_valid && req_mode == REQ_STOP && !pll_bypass)
                    state_nx = PM_STOP;
                else if (halt_req)
                    state_nx = PM_HALT;
            end
            PM_HALT, PM_IDLE: begin
                if (wake)
                    state_nx = PM_NORMAL;
            end
            PM_STOP: begin
                if (wake) begin
                    state_nx = PM_STAB;
                    tmr_load = 1'b1;
                end
            end
            PM_STAB: begin
                if (tmr_done)
                    state_nx = pll_wait ? PM_LOCKW : PM_NORMAL;
            end
            PM_LOCKW: begin
                if (pll_lock)
                    state_nx = PM_NORMAL;
            end
            default: state_nx = PM_NORMAL;
        endcase
    end

    // State register; reset returns to normal operation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= PM_NORMAL;
        else
            state <= state_nx;
    end

    // Decode the gating set of each depth.
    always_comb begin
        cpu_clk_en  = (state == PM_NORMAL);
        sys_clk_en  = (state == PM_NORMAL) || (state == PM_HALT);
        osc_en      = (state != PM_STOP);
        pll_en      = (state != PM_STOP);
        clkout_en   = sys_clk_en && !clkout_inhibit;
        mode_status = (state == PM_LOCKW) ? PM_STAB : state;
    end

    AST_BYPASS_BLOCKS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_NORMAL && pll_bypass) |=> (state != PM_STOP)); // R6
    AST_WAKE_SHALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PM_HALT || state == PM_IDLE) && wake) |=> cpu_clk_en); // R9
    AST_STOP_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_STOP) |=> (!cpu_clk_en && !sys_clk_en)); // R4
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_LOCKW && !pll_lock) |=> (state == PM_LOCKW && !cpu_clk_en)); // R5
endmodule

// File: tb/pwr_mode_ctl_bench.sv
// Bench for the standby mode sequencer. Directed corner cases come first, then
// random stimulus from a fixed seed. Every output is compared with a model built
// from the requirements.
module pwr_mode_ctl_bench;
    localparam int         CLK_P    = 10;
    localparam int         DW       = 9;
    localparam logic [7:0] KEY      = 8'hA5;
    localparam int         STAB_DEF = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_req = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic          irq_wake = 1'b0;
    logic          nmi = 1'b0;
    logic          pll_bypass = 1'b0;
    logic          pll_lock = 1'b0;
    logic          clkout_inhibit = 1'b0;
    logic          cpu_clk_en, sys_clk_en, osc_en, pll_en, clkout_en, prot_err;
    logic [2:0]    mode_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // Model of the requirements: 0 normal, 1 halt, 2 idle, 3 stop, 4 stabilizing, 5 lock wait.
    int m_mode, m_cnt, m_stab;
    bit m_armed, m_err, m_pllw;

    pwr_mode_ctl u_pwr_mode_ctl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_wake(irq_wake), .nmi(nmi),
        .pll_bypass(pll_bypass), .pll_lock(pll_lock), .clkout_inhibit(clkout_inhibit),
        .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .osc_en(osc_en),
        .pll_en(pll_en), .clkout_en(clkout_en), .mode_status(mode_status),
        .prot_err(prot_err)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [3:0] exp_en(int md);
        return {md == 0, md <= 1, md != 3, md != 3};
    endfunction

    function automatic logic [2:0] exp_status(int md);
        return (md == 5) ? 3'd4 : 3'(md);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk(tag, "enables{cpu,sys,osc,pll}", int'({cpu_clk_en, sys_clk_en, osc_en, pll_en}),
            int'(exp_en(m_mode)));
        chk("R11", "mode_status", int'(mode_status), int'(exp_status(m_mode)));
        chk("R7", "clkout_en", int'(clkout_en), int'(m_mode <= 1 && !clkout_inhibit));
        chk("R8", "prot_err", int'(prot_err), int'(m_err));
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge.
    task automatic step(bit h, bit wr, logic [1:0] a, logic [DW-1:0] d, bit irq, bit nm);
        bit prot, acc, wk;
        @(negedge clk);
        halt_req = h; reg_wr = wr; reg_addr = a; reg_wdata = d; irq_wake = irq; nmi = nm;
        @(posedge clk);
        prot = wr && (a == 2'd1 || a == 2'd2);
        acc  = prot && m_armed;
        wk   = irq || nm;
        case (m_mode)
            0: begin
                if (acc && a == 2'd1 && d[1:0] == 2'b01) m_mode = 2;
                else if (acc && a == 2'd1 && d[1:0] == 2'b10 && !pll_bypass) m_mode = 3;
                else if (h) m_mode = 1;
            end
            1, 2: if (wk) m_mode = 0;
            3: if (wk) begin m_mode = 4; m_cnt = m_stab; end
            4: if (m_cnt == 0) m_mode = m_pllw ? 5 : 0; else m_cnt--;
            5: if (pll_lock) m_mode = 0;
            default: ;
        endcase
        if (prot && !m_armed) m_err = 1'b1;
        else if (acc) m_err = 1'b0;
        if (acc && a == 2'd2) begin m_stab = int'(d[7:0]); m_pllw = d[8]; end
        if (wr) m_armed = (a == 2'd0) && (d[7:0] == KEY);
        #1;
    endtask

    task automatic idle(string tag);
        step(0, 0, 2'd0, '0, 0, 0); chk_all(tag);
    endtask

    task automatic unlock();
        step(0, 1, 2'd0, DW'(KEY), 0, 0); chk_all("R8 unlock");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; halt_req = 0; reg_wr = 0; irq_wake = 0; nmi = 0;
        repeat (2) @(posedge clk);
        m_mode = 0; m_cnt = 0; m_stab = STAB_DEF; m_armed = 0; m_err = 0; m_pllw = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog: actual=timeout expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        chk_all("R10 reset");

        // R10: the default count gives a stabilization phase of 17 cycles
        unlock(); step(0, 1, 2'd1, 9'h002, 0, 0); chk_all("R3 stop entry");
        step(0, 0, 2'd0, '0, 1, 0); chk_all("R4 wake");
        for (int i = 0; i < 18; i++) idle("R10 default count");

        // R1 and R9: HALT entry and release by irq and by nmi
        step(1, 0, 2'd0, '0, 0, 0); chk_all("R1 halt entry");
        idle("R1 halt held");
        step(0, 0, 2'd0, '0, 1, 0); chk_all("R9 irq release");
        step(1, 0, 2'd0, '0, 0, 0); chk_all("R1 halt entry");
        step(0, 0, 2'd0, '0, 0, 1); chk_all("R9 nmi release");
        step(0, 0, 2'd0, '0, 1, 1); chk_all("R9 wake ignored in normal");

        // R8: rejected writes
        step(0, 1, 2'd1, 9'h001, 0, 0); chk_all("R8 unprotected write");
        unlock(); step(0, 1, 2'd0, 9'h011, 0, 0); chk_all("R8 wrong key");
        step(0, 1, 2'd1, 9'h001, 0, 0); chk_all("R8 key not adjacent");

        // R2: IDLE entry and release with no wait
        unlock(); step(0, 1, 2'd1, 9'h001, 0, 0); chk_all("R2 idle entry");
        repeat (3) idle("R2 idle held");
        step(0, 0, 2'd0, '0, 1, 0); chk_all("R2 release no wait");

        // R12, R3, R4: count 3, then STOP
        unlock(); step(0, 1, 2'd2, 9'h003, 0, 0); chk_all("R12 timing write");
        unlock(); step(0, 1, 2'd1, 9'h002, 0, 0); chk_all("R3 stop entry");
        repeat (4) idle("R3 stop held");
        step(0, 0, 2'd0, '0, 0, 1); chk_all("R4 stabilize start");
        repeat (5) idle("R4 stabilize count");

        // R5: count 0 with PLL wait
        pll_lock = 1'b0;
        unlock(); step(0, 1, 2'd2, 9'h100, 0, 0); chk_all("R12 timing write");
        unlock(); step(0, 1, 2'd1, 9'h002, 0, 0); chk_all("R3 stop entry");
        step(0, 0, 2'd0, '0, 1, 0); chk_all("R4 zero count");
        repeat (4) idle("R5 lock wait");
        pll_lock = 1'b1; idle("R5 lock seen"); idle("R5 normal");
        pll_lock = 1'b0;

        // R6: STOP refused in bypass
        pll_bypass = 1'b1;
        unlock(); step(0, 1, 2'd1, 9'h002, 0, 0); chk_all("R6 bypass refuses stop");
        idle("R6 bypass stays normal");
        pll_bypass = 1'b0;

        // R7: inhibit in normal and in HALT
        clkout_inhibit = 1'b1;
        idle("R7 inhibit normal");
        step(1, 0, 2'd0, '0, 0, 0); chk_all("R7 inhibit halt");
        step(0, 0, 2'd0, '0, 1, 0); chk_all("R7 inhibit release");
        clkout_inhibit = 1'b0;

        // R1: a standby write beats a halt strobe in the same cycle
        unlock(); step(1, 1, 2'd1, 9'h001, 0, 0); chk_all("R1 write over halt");
        step(0, 0, 2'd0, '0, 1, 0); chk_all("R9 release");

        // R10: reset during STOP
        unlock(); step(0, 1, 2'd1, 9'h002, 0, 0); chk_all("R3 stop entry");
        do_reset(); chk_all("R10 reset from stop");

        // Random mix
        for (int i = 0; i < 2500; i++) begin
            int r;
            r = $urandom_range(0, 9);
            pll_bypass     = ($urandom_range(0, 7) == 0);
            clkout_inhibit = ($urandom_range(0, 3) == 0);
            pll_lock       = ($urandom_range(0, 2) == 0);
            case (r)
                0: step(1, 0, 2'd0, '0, 0, 0);
                1: step(0, 1, 2'd0, DW'(KEY), 0, 0);
                2: begin
                    if ($urandom_range(0, 1) == 1) unlock();
                    step(0, 1, 2'd1, DW'($urandom_range(0, 3)), 0, 0);
                end
                3: begin
                    if ($urandom_range(0, 1) == 1) unlock();
                    step(0, 1, 2'd2, {1'($urandom), 8'($urandom_range(0, 5))}, 0, 0);
                end
                4: step(0, 1, 2'($urandom), DW'($urandom), 0, 0);
                5: step(0, 0, 2'd0, '0, 1, 0);
                6: step(0, 0, 2'd0, '0, 0, 1);
                default: step($urandom_range(0, 3) == 0, 0, 2'd0, '0, 0, 0);
            endcase
            chk_all("R9 random");
        end

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule